// File: doc/BRIEF.md
# Integer Execution Unit with Signed Overflow Trap

This block is the integer execution stage of a 32-bit load/store processor. Each cycle it may accept one operation: two register operands, a 16-bit immediate, a flag that puts the extended immediate in place of the second register operand, and a 5-bit operation code. One clock later it presents the result, an overflow-exception flag and a result-write enable for the register file. Integer multiply and divide are not handled here.

The operations are signed and unsigned add and subtract, bitwise AND, OR and XOR, logical left and right shifts, arithmetic right shift, a family of set-on-comparison operations, and load-high-immediate. Only the signed add and subtract can raise the overflow exception. When they do, the write enable is withheld so the destination register keeps its old value.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes are: ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, XOR=6, LHI=7, SLL=8, SRL=9, SRA=10, SEQ=16, SNE=17, SLT=18, SGT=19, SLE=20, SGE=21, SLTU=22, SGTU=23, SLEU=24, SGEU=25. Every other code gives a result of 0 and no overflow.
- R2: An operation accepted with `in_valid`=1 at a rising edge appears on `out_valid`, `out_result` and `out_ovf` after that edge. A cycle with `in_valid`=0 gives `out_valid`=0, and `out_result` keeps its last value.
- R3: ADD and SUB produce the wrapped 32-bit two's-complement result. They set `out_ovf` exactly when the true signed result lies outside [-2^31, 2^31-1].
- R4: ADDU and SUBU produce the wrapped 32-bit result and never set `out_ovf`.
- R5: With `in_use_imm`=1 the second operand is the immediate. It is sign-extended for ADD, SUB, SEQ, SNE, SLT, SGT, SLE and SGE (0xFFFB becomes 0xFFFFFFFB), and zero-extended for every other operation.
- R6: AND, OR and XOR give the bitwise result of the two operands.
- R7: Shifts move `in_a` by the low 5 bits of the second operand. The upper bits of the shift amount are ignored. SRL fills with zeros and SRA fills with copies of bit 31.
- R8: The compare operations give 1 when their relation holds and 0 otherwise. SEQ through SGE compare as signed values, and SLTU through SGEU compare as unsigned values.
- R9: LHI gives {imm, 16'h0000} and ignores `in_a`, `in_b` and `in_use_imm`.
- R10: `out_wr_en` is 1 exactly when `out_valid` is 1 and `out_ovf` is 0. `out_ovf` is 0 whenever `out_valid` is 0.
- R11: During synchronous active-low reset, `out_valid`, `out_ovf`, `out_wr_en` and `out_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 32 | First register operand |
| in_b | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| in_use_imm | input | 1 | Use the extended immediate as the second operand |
| out_valid | output | 1 | The result is valid this cycle |
| out_result | output | 32 | Operation result |
| out_ovf | output | 1 | Signed overflow exception |
| out_wr_en | output | 1 | Result-write enable for the register file |

## Verification
The bench drives the overflow boundaries of signed add and subtract: 0x7FFFFFFF+1, 0x80000000-1, and a negative immediate. A design that tested carry instead of sign would trap on the unsigned pairs and miss real overflows, and one that kept the write enable would corrupt the destination register. It also applies large negative immediates under signed and unsigned operations, where a wrong choice of extension changes the result by 0xFFFF0000. Other vectors use shift amounts with upper bits set, which a full-width shifter would turn into zero, and signed against unsigned compares with the sign bit set, which swap their answers if the wrong view is used. LHI is given nonzero register operands and `in_use_imm` values that it must ignore.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
      OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_LHI  = 5'd7,
      OP_SLL  = 5'd8,  OP_SRL  = 5'd9,  OP_SRA  = 5'd10,
      OP_SEQ  = 5'd16, OP_SNE  = 5'd17, OP_SLT  = 5'd18, OP_SGT  = 5'd19,
      OP_SLE  = 5'd20, OP_SGE  = 5'd21, OP_SLTU = 5'd22, OP_SGTU = 5'd23,
      OP_SLEU = 5'd24, OP_SGEU = 5'd25
   } exec_op_e;

   localparam int OP_W = 5;

   function automatic logic op_wants_sext(input logic [OP_W-1:0] op);
      return (op == OP_ADD) || (op == OP_SUB) ||
             (op >= OP_SEQ && op <= OP_SGE);
   endfunction

   function automatic logic op_is_cmp(input logic [OP_W-1:0] op);
      return (op >= OP_SEQ) && (op <= OP_SGEU);
   endfunction
endpackage

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
   import int_exec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] reg_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   output logic [DATA_W-1:0] opnd_b
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign imm_ext = imm;
      end else begin : g_ext
         assign imm_ext = op_wants_sext(op) ? {{EXT_W{imm[IMM_W-1]}}, imm}
                                            : {{EXT_W{1'b0}}, imm};
      end
   endgenerate

   assign opnd_b = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/exec_addsub.sv
module exec_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              subtract,
   output logic [DATA_W-1:0] sum,
   output logic              sgn_ovf
);
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   assign b_eff = subtract ? ~b : b;
   assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, subtract};
   assign sum   = wide[DATA_W-1:0];
   // signs of the effective operands agree, but the sign of the sum differs
   assign sgn_ovf = (a[DATA_W-1] == b_eff[DATA_W-1]) &&
                    (sum[DATA_W-1] != a[DATA_W-1]);
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
   parameter int DATA_W    = 32,
   parameter bit LOG_STAGE = 1'b1
) (
   input  logic [DATA_W-1:0]         a,
   input  logic [$clog2(DATA_W)-1:0] shamt,
   input  logic                      go_right,
   input  logic                      arith,
   output logic [DATA_W-1:0]         res
);
   localparam int SH_W = $clog2(DATA_W);

   logic fill;
   assign fill = arith & a[DATA_W-1];

   generate
      if (LOG_STAGE) begin : g_log
         logic [DATA_W-1:0] lft [SH_W+1];
         logic [DATA_W-1:0] rgt [SH_W+1];
         assign lft[0] = a;
         assign rgt[0] = a;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int AMT = 1 << k;
            assign lft[k+1] = shamt[k] ? {lft[k][DATA_W-AMT-1:0], {AMT{1'b0}}} : lft[k];
            assign rgt[k+1] = shamt[k] ? {{AMT{fill}}, rgt[k][DATA_W-1:AMT]} : rgt[k];
         end
         assign res = go_right ? rgt[SH_W] : lft[SH_W];
      end else begin : g_flat
         logic [2*DATA_W-1:0] ext_r;
         assign ext_r = {{DATA_W{fill}}, a} >> shamt;
         assign res   = go_right ? ext_r[DATA_W-1:0] : (a << shamt);
      end
   endgenerate
endmodule

// File: rtl/exec_compare.sv
module exec_compare
   import int_exec_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              hit
);
   logic eq, lt_s, lt_u;

   assign eq   = (a == b);
   assign lt_s = ($signed(a) < $signed(b));
   assign lt_u = (a < b);

   always_comb begin
      unique case (op)
         OP_SEQ:  hit = eq;
         OP_SNE:  hit = !eq;
         OP_SLT:  hit = lt_s;
         OP_SGT:  hit = !lt_s && !eq;
         OP_SLE:  hit = lt_s || eq;
         OP_SGE:  hit = !lt_s;
         OP_SLTU: hit = lt_u;
         OP_SGTU: hit = !lt_u && !eq;
         OP_SLEU: hit = lt_u || eq;
         OP_SGEU: hit = !lt_u;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 16,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic              in_use_imm,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_ovf,
   output logic              out_wr_en
);
   localparam int SH_W  = $clog2(DATA_W);
   localparam int LO_W  = DATA_W - IMM_W;

   generate
      if ((1 << SH_W) != DATA_W) begin : g_bad_data_w
         $error("DATA_W must be a power of two");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm_w
         $error("IMM_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] opnd_b, sum, sh_res, lhi_val, nxt_result;
   logic              sgn_ovf, cmp_hit, nxt_ovf, is_sub;

   exec_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
      .op(in_op), .reg_b(in_b), .imm(in_imm), .use_imm(in_use_imm), .opnd_b(opnd_b)
   );

   assign is_sub = (in_op == OP_SUB) || (in_op == OP_SUBU);

   exec_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a(in_a), .b(opnd_b), .subtract(is_sub), .sum(sum), .sgn_ovf(sgn_ovf)
   );

   exec_shifter #(.DATA_W(DATA_W), .LOG_STAGE(LOG_SHIFT)) u_shift (
      .a(in_a), .shamt(opnd_b[SH_W-1:0]),
      .go_right(in_op != OP_SLL), .arith(in_op == OP_SRA), .res(sh_res)
   );

   exec_compare #(.DATA_W(DATA_W)) u_cmp (
      .op(in_op), .a(in_a), .b(opnd_b), .hit(cmp_hit)
   );

   generate
      if (LO_W == 0) begin : g_lhi_full
         assign lhi_val = in_imm;
      end else begin : g_lhi_part
         assign lhi_val = {in_imm, {LO_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      nxt_ovf = 1'b0;
      case (in_op)
         OP_ADD, OP_SUB: begin
            nxt_result = sum;
            nxt_ovf    = sgn_ovf;
         end
         OP_ADDU, OP_SUBU:        nxt_result = sum;
         OP_AND:                  nxt_result = in_a & opnd_b;
         OP_OR:                   nxt_result = in_a | opnd_b;
         OP_XOR:                  nxt_result = in_a ^ opnd_b;
         OP_LHI:                  nxt_result = lhi_val;
         OP_SLL, OP_SRL, OP_SRA:  nxt_result = sh_res;
         default: nxt_result = op_is_cmp(in_op) ? {{(DATA_W-1){1'b0}}, cmp_hit}
                                                : '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_ovf    <= 1'b0;
         out_wr_en  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_ovf   <= in_valid & nxt_ovf;
         out_wr_en <= in_valid & ~nxt_ovf;
         if (in_valid) out_result <= nxt_result;
      end
   end
endmodule

module int_exec_unit_chk
   import int_exec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [4:0]        in_op,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic              out_ovf,
   input logic              out_wr_en
);
   localparam int LO_W = DATA_W - IMM_W;

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_result));
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_op == OP_ADDU || in_op == OP_SUBU) |=> !out_ovf);
   p_ovf_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_valid && !out_wr_en);
   p_write_when_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ovf |-> out_wr_en);
   p_cmp_is_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_is_cmp(in_op) |=> out_result[DATA_W-1:1] == '0 && !out_ovf);
   generate
      if (LO_W > 0) begin : g_lhi_chk
         p_lhi_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_op == OP_LHI |=> out_result[LO_W-1:0] == '0 && !out_ovf);
      end
   endgenerate
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
   .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf),
   .out_wr_en(out_wr_en)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  in_op = '0;
   logic [31:0] in_a = '0, in_b = '0;
   logic [15:0] in_imm = '0;
   logic        in_use_imm = 1'b0;
   logic        out_valid, out_ovf, out_wr_en;
   logic [31:0] out_result;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   int_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_use_imm(in_use_imm),
      .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf),
      .out_wr_en(out_wr_en)
   );

   typedef struct {
      bit          v;
      logic [31:0] r;
      bit          ov;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [31:0] last_r = '0;

   function automatic string tag_of(input logic [4:0] op, input bit ui);
      case (op)
         0, 2:      return ui ? "R3/R5" : "R3";
         1, 3:      return ui ? "R4/R5" : "R4";
         4, 5, 6:   return ui ? "R6/R5" : "R6";
         7:         return "R9";
         8, 9, 10:  return "R7";
         default:   return (op >= 16 && op <= 25) ? (ui ? "R8/R5" : "R8") : "R1";
      endcase
   endfunction

   task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] rb,
                        input logic [15:0] imm, input bit ui,
                        output logic [31:0] r, output bit ov);
      bit          sgn;
      logic [31:0] b;
      longint      sa, sb, s;
      int          sh;
      sgn = (op == 0) || (op == 2) || (op >= 16 && op <= 21);
      b   = ui ? (sgn ? {{16{imm[15]}}, imm} : {16'h0, imm}) : rb;
      sa  = longint'($signed(a));
      sb  = longint'($signed(b));
      sh  = int'(b % 32);
      ov  = 0;
      r   = 0;
      case (op)
         0: begin s = sa + sb; r = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
         2: begin s = sa - sb; r = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
         1: r = a + b;
         3: r = a - b;
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         7: r = {imm, 16'h0};
         8: r = a << sh;
         9: r = a >> sh;
         10: begin r = a; for (int i = 0; i < sh; i++) r = {r[31], r[31:1]}; end
         16: r = (a == b) ? 1 : 0;
         17: r = (a != b) ? 1 : 0;
         18: r = (sa <  sb) ? 1 : 0;
         19: r = (sa >  sb) ? 1 : 0;
         20: r = (sa <= sb) ? 1 : 0;
         21: r = (sa >= sb) ? 1 : 0;
         22: r = (a <  b) ? 1 : 0;
         23: r = (a >  b) ? 1 : 0;
         24: r = (a <= b) ? 1 : 0;
         25: r = (a >= b) ? 1 : 0;
         default: r = 0;
      endcase
   endtask

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_out();
      exp_t e;
      if (q.size() == 0) return;
      e = q.pop_front();
      check(e.v ? e.tag : "R2", "valid", {31'h0, out_valid}, {31'h0, e.v});
      check(e.v ? e.tag : "R2", "result", out_result, e.r);
      check(e.v ? e.tag : "R10", "ovf", {31'h0, out_ovf}, {31'h0, e.ov});
      check("R10", "wr_en", {31'h0, out_wr_en}, {31'h0, e.v && !e.ov});
   endtask

   // called at a falling edge: check last cycle's result, then present a new one
   task automatic step(input bit v, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input bit ui);
      exp_t        e;
      logic [31:0] r;
      bit          ov;
      compare_out();
      in_valid = v; in_op = op; in_a = a; in_b = b; in_imm = imm; in_use_imm = ui;
      if (v) begin
         model(op, a, b, imm, ui, r, ov);
         last_r = r;
         e.ov = ov;
      end else begin
         e.ov = 0;
      end
      e.v = v; e.r = last_r; e.tag = tag_of(op, ui);
      q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11", "valid", {31'h0, out_valid}, 32'h0);
      check("R11", "result", out_result, 32'h0);
      check("R11", "ovf", {31'h0, out_ovf}, 32'h0);
      check("R11", "wr_en", {31'h0, out_wr_en}, 32'h0);
      rst_n = 1'b1;
      // R3 signed overflow corners
      step(1, 0, 32'h7FFFFFFF, 32'h1, 16'h0, 0);
      step(1, 2, 32'h80000000, 32'h1, 16'h0, 0);
      step(1, 0, 32'h80000000, 32'h0, 16'hFFFF, 1);
      step(1, 2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 0);
      step(1, 0, 32'hFFFFFFFF, 32'h1, 16'h0, 0);
      // R4 unsigned twins never trap
      step(1, 1, 32'h7FFFFFFF, 32'h1, 16'h0, 0);
      step(1, 3, 32'h80000000, 32'h1, 16'h0, 0);
      // R5 extension choice
      step(1, 0, 32'd10, 32'h0, 16'hFFFB, 1);
      step(1, 1, 32'd10, 32'h0, 16'hFFFB, 1);
      step(1, 5, 32'h0, 32'h0, 16'h8001, 1);
      step(1, 18, 32'h0, 32'h0, 16'hFFFF, 1);
      step(1, 22, 32'h0, 32'h0, 16'hFFFF, 1);
      // R7 shift amount masking, sign fill
      step(1, 10, 32'h80000010, 32'hFFFFFFE4, 16'h0, 0);
      step(1, 9, 32'h80000010, 32'h00000024, 16'h0, 0);
      step(1, 8, 32'h00000003, 32'h0000003F, 16'h0, 0);
      // R8 signed against unsigned
      step(1, 19, 32'h80000000, 32'h1, 16'h0, 0);
      step(1, 23, 32'h80000000, 32'h1, 16'h0, 0);
      // R9 LHI ignores a/b/use_imm
      step(1, 7, 32'hDEADBEEF, 32'h12345678, 16'hA5C3, 0);
      step(1, 7, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8000, 1);
      // R1 undefined codes, R2 idle hold
      step(1, 11, 32'h5, 32'h6, 16'h7, 0);
      step(0, 0, 32'h7FFFFFFF, 32'h1, 16'h0, 0);
      step(1, 31, 32'h5, 32'h6, 16'h7, 1);
      step(0, 0, 32'h0, 32'h0, 16'h0, 0);
      // random defined operations
      for (int i = 0; i < 600; i++) begin
         logic [4:0] op;
         int         k;
         k  = int'($urandom_range(0, 20));
         op = (k <= 10) ? 5'(k) : 5'(k + 5);
         step($urandom_range(0, 7) != 0, op, $urandom, ($urandom_range(0, 3) == 0) ? 32'(i) : $urandom,
              16'($urandom), $urandom_range(0, 1) == 1);
      end
      step(0, 0, 32'h0, 32'h0, 16'h0, 0);
      compare_out();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule